// File: doc/BRIEF.md
# Gap-Synchronized Multi-Group De-skew FIFO

This block lines up several groups of trigger terms that reach it at different and unknown latencies. Each group has its own source strobe and its own write pointer. A single read pointer, shared by all groups, pulls the oldest entry of every group on the same framework tick. The result is one wide word in which every group refers to the same beam crossing. Because of the buffering, the framework timing does not have to be tuned to each source's delay.

A periodic sync-gap marker realigns the pointers. On the first framework tick of each gap, the block compares every write pointer with the read pointer. If they differ, it raises an alignment error, records which groups differ, and returns all pointers to zero. A configuration input can make this return to zero happen at every gap entry. A test selector can replace the aligned terms with a programmed pattern. Sticky flags report overflow, underflow and misalignment, each per group where that applies. Source strobes are single-cycle qualifiers sampled on the framework clock `clk`.

Top module: `gap_deskew_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, all pointers, the aligned word and every error flag go to zero. With `test_sel` low, `term_out` reads zero after reset.
- R2: A high `src_stb[g]` writes group g's slice `src_terms[16g+15:16g]` into that group's 32-entry FIFO. If the FIFO already holds 32 unread entries, the write is dropped and `ovf_flag[g]` is set.
- R3: On a cycle with `fw_tick` high and `fw_gap` low, a read happens only if every group holds at least one entry that was written in an earlier cycle. Otherwise `udf_flag[g]` is set for each empty group, no pointer moves, and the aligned word is held.
- R4: A read loads the oldest entry of every group into the aligned word at the same time, group g at bits 16g+15:16g, in write order per group. The result appears on `term_out` after that clock edge.
- R5: A tick with `fw_gap` high, whose previous tick had `fw_gap` low, is the gap entry. At gap entry, each group whose write pointer differs from the read pointer sets `mis_flag[g]`, and `align_flag` is set. All pointers return to zero, and strobes on that cycle are ignored. Later ticks inside the same gap run no check.
- R6: With `cfg_gap_clear` high, every gap entry returns all pointers to zero and ignores that cycle's strobes, even when all pointers match. No flag is raised in that case. With `cfg_gap_clear` low and all pointers matching, gap entry changes nothing, and a strobe on that cycle is written.
- R7: With `test_sel` high, `term_out` equals `test_pattern`. With it low, `term_out` is the aligned word. Reads continue in both modes.
- R8: Error flags stay set until `err_clr` is high at a clock edge. A flag that is set again on the same edge as the clear remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Framework clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_stb | input | 4 | Per-group write strobe |
| src_terms | input | 64 | Source terms, 16 per group |
| fw_tick | input | 1 | Framework crossing qualifier |
| fw_gap | input | 1 | Sync-gap marker |
| cfg_gap_clear | input | 1 | Zero pointers on every gap entry |
| test_sel | input | 1 | Select test pattern onto the output |
| test_pattern | input | 64 | Programmed test terms |
| err_clr | input | 1 | Clear all sticky flags |
| term_out | output | 64 | Aligned (or test) terms |
| ovf_flag | output | 4 | Sticky overflow per group |
| udf_flag | output | 4 | Sticky underflow per group |
| mis_flag | output | 4 | Sticky gap mismatch per group |
| align_flag | output | 1 | Sticky gap alignment error |

## Verification
The hardest case to reach is a gap entry whose outcome depends on pointer state that the ports do not show. Examples are a matched gap entry where the only visible effect of an unconditional clear is a dropped strobe, and a full group that has to be driven past 32 entries. Directed sequences set up these states on purpose: one group is filled to overflow, strobes land exactly on the entry tick, and an underflow afterwards shows whether the pointers were zeroed. A long random phase with seeded strobes, ticks, gaps and clears then runs against a queue-based model.

// File: rtl/gdf_pkg.sv
// Shared defaults for the gap-synchronized de-skew FIFO.
package gdf_pkg;
    parameter int GDF_GROUPS = 4;
    parameter int GDF_GRP_W  = 16;
    parameter int GDF_DEPTH  = 32;
endpackage

// File: rtl/gdf_lane.sv
// One group's FIFO: stores strobed terms, owns the write pointer.
// Assumes the strobe is a one-cycle qualifier on clk and that the
// read pointer comes from the shared controller.
module gdf_lane #(
    parameter int GRP_W = 16,
    parameter int DEPTH = 32,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [GRP_W-1:0] din,
    input  logic [PW-1:0]    rptr,
    input  logic             realign,
    output logic [GRP_W-1:0] head,
    output logic [PW-1:0]    occ,
    output logic             ovf
);
    localparam int AW = PW - 1;

    logic [GRP_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic             full;
    logic             wr_ok;

    assign occ   = wptr - rptr;
    assign full  = (occ == PW'(DEPTH));
    assign wr_ok = stb && !full && !realign;
    assign ovf   = stb && full && !realign;
    assign head  = mem[rptr[AW-1:0]];

    // storage write, no reset needed for the array
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr[AW-1:0]] <= din;
    end

    // write pointer: zero on reset or realign, step on accepted write
    always_ff @(posedge clk) begin
        if (!rst_n || realign) wptr <= '0;
        else if (wr_ok)        wptr <= wptr + 1'b1;
    end

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && occ == PW'(DEPTH) && !realign) |=> (wptr == $past(wptr)));
    p_wptr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (wptr == '0));
endmodule

// File: rtl/gdf_ctrl.sv
// Shared read pointer, gap-entry check and sticky error flags.
// Assumes lane occupancies are computed against the rptr it drives.
module gdf_ctrl #(
    parameter int NG = 4,
    parameter int PW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fw_tick,
    input  logic                 fw_gap,
    input  logic                 cfg_gap_clear,
    input  logic                 err_clr,
    input  logic [NG-1:0][PW-1:0] occ,
    input  logic [NG-1:0]        ovf_pulse,
    output logic [PW-1:0]        rptr,
    output logic                 realign,
    output logic                 rd_go,
    output logic [NG-1:0]        ovf_flag,
    output logic [NG-1:0]        udf_flag,
    output logic [NG-1:0]        mis_flag,
    output logic                 align_flag
);
    logic          last_gap;
    logic          gap_entry;
    logic [NG-1:0] nonempty;
    logic [NG-1:0] udf_set;
    logic [NG-1:0] mis_set;

    // per-group non-empty status (mismatch and readiness share it)
    always_comb begin
        for (int g = 0; g < NG; g++) nonempty[g] = (occ[g] != '0);
    end

    assign gap_entry = fw_tick && fw_gap && !last_gap;
    assign realign   = gap_entry && (cfg_gap_clear || (|nonempty));
    assign rd_go     = fw_tick && !fw_gap && (&nonempty);
    assign udf_set   = (fw_tick && !fw_gap) ? ~nonempty : '0;
    assign mis_set   = gap_entry ? nonempty : '0;

    // remember the gap level of the previous tick
    always_ff @(posedge clk) begin
        if (!rst_n)       last_gap <= 1'b0;
        else if (fw_tick) last_gap <= fw_gap;
    end

    // shared read pointer
    always_ff @(posedge clk) begin
        if (!rst_n || realign) rptr <= '0;
        else if (rd_go)        rptr <= rptr + 1'b1;
    end

    // sticky flags, a new set wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag   <= '0;
            udf_flag   <= '0;
            mis_flag   <= '0;
            align_flag <= 1'b0;
        end else begin
            ovf_flag   <= (err_clr ? '0 : ovf_flag) | ovf_pulse;
            udf_flag   <= (err_clr ? '0 : udf_flag) | udf_set;
            mis_flag   <= (err_clr ? '0 : mis_flag) | mis_set;
            align_flag <= (err_clr ? 1'b0 : align_flag) | (|mis_set);
        end
    end

    p_rptr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (rptr == '0));
    p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((udf_flag & $past(udf_flag)) == $past(udf_flag)));
    p_gap_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_gap && !realign) |=> (rptr == $past(rptr)));
endmodule

// File: rtl/gap_deskew_fifo.sv
// Top: per-group lanes, shared controller, aligned word and test mux.
// Assumes all inputs are synchronous to clk.
module gap_deskew_fifo
    import gdf_pkg::*;
#(
    parameter int NUM_GRP = GDF_GROUPS,
    parameter int GRP_W   = GDF_GRP_W,
    parameter int DEPTH   = GDF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP-1:0]       src_stb,
    input  logic [NUM_GRP*GRP_W-1:0] src_terms,
    input  logic                     fw_tick,
    input  logic                     fw_gap,
    input  logic                     cfg_gap_clear,
    input  logic                     test_sel,
    input  logic [NUM_GRP*GRP_W-1:0] test_pattern,
    input  logic                     err_clr,
    output logic [NUM_GRP*GRP_W-1:0] term_out,
    output logic [NUM_GRP-1:0]       ovf_flag,
    output logic [NUM_GRP-1:0]       udf_flag,
    output logic [NUM_GRP-1:0]       mis_flag,
    output logic                     align_flag
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam int TW = NUM_GRP * GRP_W;

    logic [NUM_GRP-1:0][PW-1:0]    occ;
    logic [NUM_GRP-1:0][GRP_W-1:0] head;
    logic [NUM_GRP-1:0]            ovf_pulse;
    logic [PW-1:0]                 rptr;
    logic                          realign;
    logic                          rd_go;
    logic [TW-1:0]                 fifo_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
        gdf_lane #(.GRP_W(GRP_W), .DEPTH(DEPTH), .PW(PW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (src_stb[g]),
            .din     (src_terms[g*GRP_W +: GRP_W]),
            .rptr    (rptr),
            .realign (realign),
            .head    (head[g]),
            .occ     (occ[g]),
            .ovf     (ovf_pulse[g])
        );
    end

    gdf_ctrl #(.NG(NUM_GRP), .PW(PW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fw_tick       (fw_tick),
        .fw_gap        (fw_gap),
        .cfg_gap_clear (cfg_gap_clear),
        .err_clr       (err_clr),
        .occ           (occ),
        .ovf_pulse     (ovf_pulse),
        .rptr          (rptr),
        .realign       (realign),
        .rd_go         (rd_go),
        .ovf_flag      (ovf_flag),
        .udf_flag      (udf_flag),
        .mis_flag      (mis_flag),
        .align_flag    (align_flag)
    );

    // aligned word: all group heads captured together on a read
    always_ff @(posedge clk) begin
        if (!rst_n)     fifo_q <= '0;
        else if (rd_go) fifo_q <= head;
    end

    assign term_out = test_sel ? test_pattern : fifo_q;

    p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(fifo_q));
endmodule

// File: tb/gap_deskew_fifo_bench.sv
module gap_deskew_fifo_bench;
    localparam int NG = 4;
    localparam int GW = 16;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  b_stb = '0;
    logic [63:0] b_terms = '0;
    logic        b_tick = 1'b0;
    logic        b_gap = 1'b0;
    logic        b_always = 1'b0;
    logic        b_tsel = 1'b0;
    logic [63:0] b_pat = '0;
    logic        b_clr = 1'b0;
    logic [63:0] term_out;
    logic [3:0]  ovf_flag, udf_flag, mis_flag;
    logic        align_flag;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [15:0] mq [NG][$];
    logic [63:0] m_q;
    logic [3:0]  m_ovf, m_udf, m_mis;
    logic        m_align;
    logic        m_last_gap;

    always #10 clk = ~clk;

    gap_deskew_fifo u_gap_deskew_fifo (
        .clk(clk), .rst_n(rst_n), .src_stb(b_stb), .src_terms(b_terms),
        .fw_tick(b_tick), .fw_gap(b_gap), .cfg_gap_clear(b_always),
        .test_sel(b_tsel), .test_pattern(b_pat), .err_clr(b_clr),
        .term_out(term_out), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .mis_flag(mis_flag), .align_flag(align_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_out();
        return b_tsel ? b_pat : m_q;
    endfunction

    // one clock: update the model from pre-edge state, then compare
    task automatic step();
        logic first_gap, realign, rd;
        logic [3:0] nonempty, ovf_s, udf_s, mis_s;
        for (int g = 0; g < NG; g++) nonempty[g] = (mq[g].size() != 0);
        first_gap = b_tick && b_gap && !m_last_gap;
        realign   = first_gap && (b_always || (|nonempty));
        rd        = b_tick && !b_gap && (&nonempty);
        udf_s     = (b_tick && !b_gap) ? ~nonempty : 4'b0;
        mis_s     = first_gap ? nonempty : 4'b0;
        for (int g = 0; g < NG; g++)
            ovf_s[g] = b_stb[g] && (mq[g].size() == DEPTH) && !realign;
        m_ovf   = (b_clr ? 4'b0 : m_ovf) | ovf_s;
        m_udf   = (b_clr ? 4'b0 : m_udf) | udf_s;
        m_mis   = (b_clr ? 4'b0 : m_mis) | mis_s;
        m_align = (b_clr ? 1'b0 : m_align) | (|mis_s);
        if (realign) begin
            for (int g = 0; g < NG; g++) mq[g].delete();
        end else begin
            if (rd) for (int g = 0; g < NG; g++) m_q[g*GW +: GW] = mq[g].pop_front();
            for (int g = 0; g < NG; g++)
                if (b_stb[g] && !ovf_s[g]) mq[g].push_back(b_terms[g*GW +: GW]);
        end
        if (b_tick) m_last_gap = b_gap;
        @(posedge clk);
        #1;
        chk(b_tsel ? "R7 term_out" : "R4 term_out", term_out, exp_out());
        chk("R2 ovf_flag", {60'b0, ovf_flag}, {60'b0, m_ovf});
        chk("R3 udf_flag", {60'b0, udf_flag}, {60'b0, m_udf});
        chk("R5 mis_flag", {60'b0, mis_flag}, {60'b0, m_mis});
        chk("R5 align_flag", {63'b0, align_flag}, {63'b0, m_align});
    endtask

    task automatic idle();
        b_stb = '0; b_tick = 0; b_gap = 0; b_clr = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_F1F0));
        for (int g = 0; g < NG; g++) mq[g].delete();
        m_q = '0; m_ovf = '0; m_udf = '0; m_mis = '0; m_align = 0; m_last_gap = 0;
        #1;
        // R1: reset state, with junk on the inputs
        b_stb = 4'hF; b_tick = 1; b_terms = 64'hDEAD_BEEF_0123_4567;
        repeat (3) @(posedge clk);
        #1;
        idle();
        rst_n = 1'b1;
        chk("R1 term_out after reset", term_out, 64'h0);
        chk("R1 flags after reset", {51'b0, ovf_flag, udf_flag, mis_flag, align_flag}, 64'h0);

        // R4: three words per group, then three aligned reads
        for (int i = 0; i < 3; i++) begin
            b_stb = 4'hF;
            b_terms = {16'h3000 + 16'(i), 16'h2000 + 16'(i), 16'h1000 + 16'(i), 16'h0000 + 16'(i)};
            step();
        end
        idle(); b_tick = 1;
        step();
        chk("R4 first aligned word", term_out, 64'h3000_2000_1000_0000);
        step(); step();
        chk("R4 third aligned word", term_out, 64'h3002_2002_1002_0002);

        // R3: read when empty flags every group, word held
        step();
        chk("R3 underflow all groups", {60'b0, udf_flag}, 64'hF);
        chk("R3 word held on underflow", term_out, 64'h3002_2002_1002_0002);
        // R8: set wins over clear on the same edge
        b_clr = 1; step();
        chk("R8 set wins over clear", {60'b0, udf_flag}, 64'hF);
        idle(); b_clr = 1; step();
        chk("R8 clear empties flags", {60'b0, udf_flag}, 64'h0);

        // R2: overflow group 1 past 32 entries
        idle(); b_stb = 4'b0010;
        for (int i = 0; i < DEPTH + 1; i++) begin
            b_terms = {32'h0, 16'(16'hA000 + i), 16'h0};
            step();
        end
        chk("R2 overflow only group 1", {60'b0, ovf_flag}, 64'h2);

        // R5: gap entry with group 1 full, others empty
        idle(); b_tick = 1; b_gap = 1; step();
        chk("R5 mismatch group 1", {60'b0, mis_flag}, 64'h2);
        chk("R5 align flag", {63'b0, align_flag}, 64'h1);
        // inside the same gap: write group 0, no second check
        idle(); b_clr = 1; step();
        idle(); b_tick = 1; b_gap = 1; b_stb = 4'b0001; b_terms = 64'h5; step();
        chk("R5 no check after gap entry", {60'b0, mis_flag}, 64'h0);
        // leave gap, drain: realign emptied group 1
        idle(); b_tick = 1; step();
        chk("R5 pointers zeroed", {60'b0, udf_flag}, 64'hE);

        // R6: matched gap entry, option off: strobe that cycle is kept
        idle(); b_always = 0; b_tick = 1; b_gap = 1; step(); // realign (group 0 held 1)
        idle(); b_tick = 1; step();
        idle(); b_clr = 1; step();
        idle(); b_tick = 1; b_gap = 1; b_stb = 4'b0001; b_terms = 64'h77; step();
        chk("R6 matched entry no error", {63'b0, align_flag}, 64'h0);
        idle(); b_tick = 1; step();
        chk("R6 strobe kept without option", {60'b0, udf_flag}, 64'hE);
        // option on: realign again, then matched entry drops the strobe
        idle(); b_always = 1; b_tick = 1; b_gap = 1; step();
        idle(); b_tick = 1; step();
        idle(); b_clr = 1; step();
        idle(); b_tick = 1; b_gap = 1; b_stb = 4'b0001; b_terms = 64'h99; step();
        chk("R6 unconditional clear no error", {63'b0, align_flag}, 64'h0);
        idle(); b_tick = 1; step();
        chk("R6 strobe dropped on clear", {60'b0, udf_flag}, 64'hF);

        // R7: test pattern replaces output, then released
        idle(); b_tsel = 1; b_pat = 64'hC0FF_EE00_1234_ABCD; step();
        chk("R7 test pattern on output", term_out, 64'hC0FF_EE00_1234_ABCD);
        b_tsel = 0; step();

        // random phase
        b_clr = 1; step();
        for (int i = 0; i < 3000; i++) begin
            b_stb   = 4'($urandom) | 4'($urandom);
            b_terms = {$urandom, $urandom};
            b_tick  = ($urandom % 3) != 0;
            b_gap   = (i % 50) >= 46;
            if ((i % 50) == 46) b_always = 1'($urandom);
            b_clr   = ($urandom % 20) == 0;
            b_tsel  = ($urandom % 8) == 0;
            b_pat   = {$urandom, $urandom};
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule